// File: doc/BRIEF.md
# SRAM Power-Up Entropy Harvester

This controller gathers entropy from the random state that an external asynchronous SRAM wakes up in. It cuts the memory's supply through an external transistor switch, holds it off for a programmable time, and restores it. It then waits a programmable settle time, reads every address in ascending order and hands each word to an external hash core over a valid/ready stream. The raw words never leave the block except as input to the hash. Biased cells give the same value in every sample, so only the conditioned digest is useful.

In an optional mode, each cycle starts by filling the whole array with words from an external pattern generator before power is cut. This makes any contents left behind by data remanence unpredictable. After the final word, the controller waits for the hash core to report a digest and counts one sample. It then loops while the run input stays high. While power is off, every SRAM line is held low and the data bus is released, so the chip cannot be back-powered through its pins.

Top module: `sram_entropy_harvester`

## Requirements
- R1: After reset the supply enable is high, all SRAM strobes, the data-drive enable, hash_valid and prng_ready are low, busy is low and sample_count is zero.
- R2: With run high in idle a harvesting cycle starts and busy stays high until the cycle ends. run is only looked at in idle and when a digest arrives. When run is low at that point the block returns to idle with power on.
- R3: With prefill_en high at the start of a cycle, each address from 0 upward to the top is written once, in ascending order. Each write uses the next word accepted from the pattern port (prng_valid and prng_ready both high). A write is a single cycle with sram_ce, sram_we and sram_data_oe high and sram_oe low. Power is cut only after the top address has been written.
- R4: sram_pwr_en stays low for max(off_cycles, 1) consecutive clock cycles.
- R5: While sram_pwr_en is low, sram_ce, sram_we, sram_oe, sram_data_oe, sram_addr and sram_wdata are all zero.
- R6: After power returns, the block waits max(settle_cycles, 1) cycles with no chip enable before the first read cycle.
- R7: Every address is read in ascending order in a one-cycle read (sram_ce and sram_oe high). The word sampled at the end of that cycle is then offered on hash_data with hash_valid, and held unchanged until hash_ready is high.
- R8: hash_last is high together with the word of the top address and with no other word.
- R9: Once the last word is accepted, the block does nothing until digest_valid is high. At that point sample_count increases by exactly one.
- R10: digest_valid arriving in any other phase is ignored and does not change sample_count.
- R11: With prefill_en low, no write strobe occurs and prng_ready stays low for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Keep harvesting while high |
| prefill_en | input | 1 | Fill the array with pattern words before power-off |
| off_cycles | input | CNT_W | Power-off duration in cycles |
| settle_cycles | input | CNT_W | Power-up settle time in cycles |
| sram_pwr_en | output | 1 | Drives the SRAM supply switch, high = powered |
| sram_ce | output | 1 | Chip enable, active high |
| sram_we | output | 1 | Write enable, active high |
| sram_oe | output | 1 | Output enable, active high |
| sram_data_oe | output | 1 | Enables the pad driver of the data bus |
| sram_addr | output | ADDR_W | Address bus |
| sram_wdata | output | DATA_W | Data driven on writes |
| sram_rdata | input | DATA_W | Data read from the bus |
| prng_valid | input | 1 | Pattern word available |
| prng_data | input | DATA_W | Pattern word |
| prng_ready | output | 1 | Block takes a pattern word |
| hash_valid | output | 1 | Readout word offered to the hash |
| hash_data | output | DATA_W | Readout word |
| hash_last | output | 1 | Word is the final one of the sample |
| hash_ready | input | 1 | Hash accepts the word |
| digest_valid | input | 1 | Hash has finished the digest |
| busy | output | 1 | A harvesting cycle is in progress |
| sample_count | output | SCNT_W | Completed digests |

## Verification
The bench builds the block with a 3-bit address and 8-bit words, so an array of eight words. Every sample therefore reaches the top-address wrap, the hash_last word and both the fill and readout address sequences many times in a short run. Three samples run back to back: one without prefill using 5 off and 3 settle cycles, and two with prefill that use zero and one as counts. These exercise the lower clamp of both timers. A stalling hash_ready and a gappy pattern stream exercise holding behaviour, and a stray digest pulse during readout tests that it is ignored.

// File: rtl/sram_harv_pkg.sv
// Shared types of the SRAM entropy harvester.
package sram_harv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_WRITE,
        ST_OFF,
        ST_SETTLE,
        ST_READ,
        ST_HASH,
        ST_DIGEST
    } harv_state_t;
endpackage

// File: rtl/sram_harv_timer.sv
// Countdown used for the power-off and settle waits.
// Assumes load has priority over tick; done is high when one cycle or less remains,
// so a value of zero or one both give a single-cycle wait.
module sram_harv_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] remain;

    // Load a new wait length or count the current one down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (tick && remain > ONE)
            remain <= remain - ONE;
    end

    assign done = (remain <= ONE);
endmodule

// File: rtl/sram_harv_addr.sv
// Address sequencer that walks the whole array once for filling and once for readout.
// Assumes the array holds 2**ADDR_W words; clr wins over step.
module sram_harv_addr #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    // Advance or rewind the word pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            addr <= '0;
        else if (step)
            addr <= addr + ONE;
    end

    assign at_last = (addr == TOP);
endmodule

// File: rtl/sram_entropy_harvester.sv
// Top of the SRAM entropy harvester: sequences optional prefill, power-off,
// settle, full readout into the hash stream and the digest wait.
// Assumes an asynchronous SRAM whose read data is valid within one clock of
// chip/output enable, and an external tri-state pad driven by sram_data_oe.
module sram_entropy_harvester
    import sram_harv_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int SCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              prefill_en,
    input  logic [CNT_W-1:0]  off_cycles,
    input  logic [CNT_W-1:0]  settle_cycles,
    output logic              sram_pwr_en,
    output logic              sram_ce,
    output logic              sram_we,
    output logic              sram_oe,
    output logic              sram_data_oe,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    input  logic [DATA_W-1:0] sram_rdata,
    input  logic              prng_valid,
    input  logic [DATA_W-1:0] prng_data,
    output logic              prng_ready,
    output logic              hash_valid,
    output logic [DATA_W-1:0] hash_data,
    output logic              hash_last,
    input  logic              hash_ready,
    input  logic              digest_valid,
    output logic              busy,
    output logic [SCNT_W-1:0] sample_count
);
    localparam logic [SCNT_W-1:0] SCNT_ONE = {{(SCNT_W-1){1'b0}}, 1'b1};

    harv_state_t       state, nxt;
    logic              tmr_load, tmr_done, tmr_tick;
    logic [CNT_W-1:0]  tmr_val;
    logic              a_clr, a_step, at_last;
    logic [ADDR_W-1:0] word_addr;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              cnt_inc;

    sram_harv_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .tick    (tmr_tick),
        .done    (tmr_done)
    );

    sram_harv_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (a_clr),
        .step   (a_step),
        .addr   (word_addr),
        .at_last(at_last)
    );

    assign tmr_tick = (state == ST_OFF) || (state == ST_SETTLE);

    // Next-state decode, timer loads and address stepping.
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = off_cycles;
        a_clr    = 1'b0;
        a_step   = 1'b0;
        cnt_inc  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (run) begin
                    if (prefill_en) begin
                        nxt = ST_FILL;
                    end else begin
                        nxt      = ST_OFF;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_FILL: begin
                if (prng_valid) nxt = ST_WRITE;
            end
            ST_WRITE: begin
                if (at_last) begin
                    a_clr    = 1'b1;
                    nxt      = ST_OFF;
                    tmr_load = 1'b1;
                end else begin
                    a_step = 1'b1;
                    nxt    = ST_FILL;
                end
            end
            ST_OFF: begin
                if (tmr_done) begin
                    nxt      = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = settle_cycles;
                end
            end
            ST_SETTLE: begin
                if (tmr_done) nxt = ST_READ;
            end
            ST_READ: begin
                nxt = ST_HASH;
            end
            ST_HASH: begin
                if (hash_ready) begin
                    if (at_last) begin
                        a_clr = 1'b1;
                        nxt   = ST_DIGEST;
                    end else begin
                        a_step = 1'b1;
                        nxt    = ST_READ;
                    end
                end
            end
            ST_DIGEST: begin
                if (digest_valid) begin
                    cnt_inc = 1'b1;
                    if (!run) begin
                        nxt = ST_IDLE;
                    end else if (prefill_en) begin
                        nxt = ST_FILL;
                    end else begin
                        nxt      = ST_OFF;
                        tmr_load = 1'b1;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Capture pattern words for writing and array words for the hash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (state == ST_FILL && prng_valid) wdata_q <= prng_data;
            if (state == ST_READ)               rdata_q <= sram_rdata;
        end
    end

    // Completed-sample counter.
    always_ff @(posedge clk) begin
        if (!rst_n)       sample_count <= '0;
        else if (cnt_inc) sample_count <= sample_count + SCNT_ONE;
    end

    assign sram_pwr_en  = (state != ST_OFF);
    assign sram_ce      = (state == ST_WRITE) || (state == ST_READ);
    assign sram_we      = (state == ST_WRITE);
    assign sram_oe      = (state == ST_READ);
    assign sram_data_oe = (state == ST_WRITE);
    assign sram_addr    = sram_ce ? word_addr : '0;
    assign sram_wdata   = (state == ST_WRITE) ? wdata_q : '0;
    assign prng_ready   = (state == ST_FILL);
    assign hash_valid   = (state == ST_HASH);
    assign hash_data    = rdata_q;
    assign hash_last    = (state == ST_HASH) && at_last;
    assign busy         = (state != ST_IDLE);
endmodule

// File: rtl/sram_harv_checker.sv
// Protocol checker for the SRAM entropy harvester, bound to every instance.
// Assumes only the top-level ports; it looks at no internal state.
module sram_harv_checker #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int SCNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sram_pwr_en,
    input logic              sram_ce,
    input logic              sram_we,
    input logic              sram_oe,
    input logic              sram_data_oe,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_wdata,
    input logic              prng_ready,
    input logic              hash_valid,
    input logic [DATA_W-1:0] hash_data,
    input logic              hash_last,
    input logic              hash_ready,
    input logic              busy,
    input logic [SCNT_W-1:0] sample_count
);
    localparam logic [SCNT_W-1:0] SCNT_ONE = {{(SCNT_W-1){1'b0}}, 1'b1};

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sram_pwr_en && !hash_valid && !prng_ready && !sram_ce)); // R1

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_pwr_en |-> (!sram_ce && !sram_we && !sram_oe && !sram_data_oe
                          && sram_addr == '0 && sram_wdata == '0)); // R5

    AST_WRITE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> (sram_ce && sram_data_oe && !sram_oe && sram_pwr_en)); // R3

    AST_HASH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hash_valid && !hash_ready) |=> (hash_valid && $stable(hash_data) && $stable(hash_last))); // R7

    AST_HASH_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hash_valid) |-> $past(sram_oe)); // R7

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        hash_last |-> hash_valid); // R8

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_count != $past(sample_count)) |-> (sample_count == $past(sample_count) + SCNT_ONE)); // R9
endmodule

bind sram_entropy_harvester sram_harv_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .SCNT_W(SCNT_W)
) u_harv_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sram_pwr_en (sram_pwr_en),
    .sram_ce     (sram_ce),
    .sram_we     (sram_we),
    .sram_oe     (sram_oe),
    .sram_data_oe(sram_data_oe),
    .sram_addr   (sram_addr),
    .sram_wdata  (sram_wdata),
    .prng_ready  (prng_ready),
    .hash_valid  (hash_valid),
    .hash_data   (hash_data),
    .hash_last   (hash_last),
    .hash_ready  (hash_ready),
    .busy        (busy),
    .sample_count(sample_count)
);

// File: tb/sram_entropy_harvester_test.sv
// Bench: behavioural SRAM with a changing power-up pattern, a stalling hash
// sink and a gappy pattern source; every clock is compared with expectations
// kept in queues and counters.
module sram_entropy_harvester_test;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 8;
    localparam int SCNT_W = 8;
    localparam int WORDS  = 1 << ADDR_W;
    localparam int NSAMP  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic prefill_en = 1'b0;
    logic [CNT_W-1:0] off_cycles = 8'd5;
    logic [CNT_W-1:0] settle_cycles = 8'd3;
    logic sram_pwr_en, sram_ce, sram_we, sram_oe, sram_data_oe;
    logic [ADDR_W-1:0] sram_addr;
    logic [DATA_W-1:0] sram_wdata, sram_rdata;
    logic prng_valid = 1'b0;
    logic [DATA_W-1:0] prng_data = '0;
    logic prng_ready;
    logic hash_valid, hash_last;
    logic [DATA_W-1:0] hash_data;
    logic hash_ready = 1'b0;
    logic digest_valid = 1'b0;
    logic busy;
    logic [SCNT_W-1:0] sample_count;

    always #2 clk = ~clk;

    sram_entropy_harvester #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SCNT_W(SCNT_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .run(run), .prefill_en(prefill_en),
        .off_cycles(off_cycles), .settle_cycles(settle_cycles),
        .sram_pwr_en(sram_pwr_en), .sram_ce(sram_ce), .sram_we(sram_we),
        .sram_oe(sram_oe), .sram_data_oe(sram_data_oe), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .prng_valid(prng_valid), .prng_data(prng_data), .prng_ready(prng_ready),
        .hash_valid(hash_valid), .hash_data(hash_data), .hash_last(hash_last),
        .hash_ready(hash_ready), .digest_valid(digest_valid),
        .busy(busy), .sample_count(sample_count)
    );

    logic [DATA_W-1:0] mem [WORDS];
    assign sram_rdata = (sram_pwr_en && sram_ce && sram_oe) ? mem[sram_addr] : '0;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit pwr_prev = 1;
    bit awaiting = 0;
    bit stray_done = 0;
    bit in_settle = 0;
    int cyc = 0;
    int off_run = 0;
    int settle_run = 0;
    int fill_idx = 0;
    int wait_cnt = 0;
    int powerups = 0;
    int exp_count = 0;
    logic [DATA_W-1:0] exp_q [$];
    logic [DATA_W-1:0] prng_q [$];
    logic [DATA_W-1:0] lfsr = 8'hA7;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [DATA_W-1:0] pu_val(input int a, input int s);
        return DATA_W'(a * 37 + s * 11 + 90);
    endfunction

    function automatic int atleast1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    // Per-clock reference checks and stimulus for the handshake ports.
    always @(negedge clk) begin
        if (rst_n && started) begin
            cyc++;
            if (cyc > 20000) begin
                chk(0, "R2 watchdog", cyc, 0);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
            chk(sample_count == SCNT_W'(exp_count), "R9/R10 sample_count", sample_count, exp_count);
            if (!sram_pwr_en) begin
                chk(!sram_ce && !sram_we && !sram_oe && !sram_data_oe && sram_addr == 0 && sram_wdata == 0,
                    "R5 lines low while off", {sram_ce, sram_we, sram_oe, sram_data_oe}, 0);
                chk(busy, "R2 busy while off", busy, 1);
                off_run++;
            end
            if (!sram_pwr_en && pwr_prev) begin
                chk(fill_idx == (prefill_en ? WORDS : 0), "R3/R11 words filled before power-off",
                    fill_idx, prefill_en ? WORDS : 0);
                fill_idx = 0;
            end
            if (sram_pwr_en && !pwr_prev) begin
                chk(off_run == atleast1(int'(off_cycles)), "R4 power-off length", off_run, atleast1(int'(off_cycles)));
                off_run = 0;
                for (int a = 0; a < WORDS; a++) begin
                    mem[a] = pu_val(a, powerups);
                    exp_q.push_back(pu_val(a, powerups));
                end
                powerups++;
                in_settle = 1;
                settle_run = 0;
            end
            if (in_settle) begin
                if (sram_oe) begin
                    chk(settle_run == atleast1(int'(settle_cycles)), "R6 settle length",
                        settle_run, atleast1(int'(settle_cycles)));
                    in_settle = 0;
                end else begin
                    chk(!sram_ce, "R6 no access while settling", sram_ce, 0);
                    settle_run++;
                end
            end
            if (sram_ce && sram_we) begin
                chk(prefill_en, "R11 write without prefill", 1, 0);
                chk(sram_addr == ADDR_W'(fill_idx), "R3 fill address order", sram_addr, fill_idx);
                if (prng_q.size() > 0) begin
                    logic [DATA_W-1:0] w;
                    w = prng_q.pop_front();
                    chk(sram_wdata == w, "R3 fill data", sram_wdata, w);
                end else begin
                    chk(0, "R3 write with no pattern word", 1, 0);
                end
                mem[sram_addr] = sram_wdata;
                fill_idx++;
            end
            if (prng_ready) chk(prefill_en, "R11 prng_ready without prefill", prng_ready, 0);
            if (awaiting) begin
                chk(!hash_valid && sram_pwr_en && !sram_ce && !prng_ready, "R9 idle while awaiting digest",
                    {hash_valid, sram_ce, prng_ready}, 0);
                chk(busy, "R2 busy while awaiting digest", busy, 1);
            end

            // Drive inputs for the next rising edge.
            hash_ready   = (cyc % 3) != 1;
            prng_valid   = (cyc % 2) == 0;
            lfsr         = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            prng_data    = lfsr;
            digest_valid = 1'b0;
            if (awaiting) begin
                wait_cnt++;
                if (wait_cnt == 4) begin
                    digest_valid = 1'b1;
                    awaiting = 0;
                    exp_count++;
                    if (exp_count == 1) begin
                        prefill_en = 1'b1; off_cycles = 8'd0; settle_cycles = 8'd1;
                    end else if (exp_count == 2) begin
                        prefill_en = 1'b1; off_cycles = 8'd1; settle_cycles = 8'd0;
                    end else begin
                        run = 1'b0;
                    end
                end
            end else if (hash_valid && !stray_done && exp_q.size() == WORDS - 2) begin
                digest_valid = 1'b1;   // R10 stray pulse during readout
                stray_done = 1;
            end

            // Transfers that happen at the next rising edge.
            if (prng_valid && prng_ready) prng_q.push_back(prng_data);
            if (hash_valid && hash_ready) begin
                if (exp_q.size() > 0) begin
                    logic [DATA_W-1:0] e;
                    bit lst;
                    lst = (exp_q.size() == 1);
                    e = exp_q.pop_front();
                    chk(hash_data == e, "R7 readout word", hash_data, e);
                    chk(hash_last == lst, "R8 last flag", hash_last, lst);
                    if (lst) begin
                        awaiting = 1;
                        wait_cnt = 0;
                    end
                end else begin
                    chk(0, "R7 unexpected word", hash_data, 0);
                end
            end
            pwr_prev = sram_pwr_en;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(sram_pwr_en && !sram_ce && !sram_we && !sram_oe && !sram_data_oe, "R1 reset strobes",
            {sram_pwr_en, sram_ce, sram_we, sram_oe, sram_data_oe}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !hash_valid && !prng_ready, "R1 reset status", {busy, hash_valid, prng_ready}, 0);
        chk(sample_count == 0, "R1 reset count", sample_count, 0);
        chk(sram_pwr_en, "R1 power on at reset", sram_pwr_en, 1);
        repeat (2) @(negedge clk);
        chk(!busy, "R2 idle while run low", busy, 0);
        run = 1'b1;
        started = 1;
        wait (exp_count == NSAMP);
        repeat (6) @(negedge clk);
        chk(!busy, "R2 back to idle", busy, 0);
        chk(sram_pwr_en, "R2 power on in idle", sram_pwr_en, 1);
        chk(sample_count == SCNT_W'(NSAMP), "R9 final count", sample_count, NSAMP);
        chk(stray_done, "R10 stray pulse issued", stray_done, 1);
        chk(powerups == NSAMP, "R4 number of power cycles", powerups, NSAMP);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule